// File: doc/BRIEF.md
# Signal Strength Averaging and Link Quality Unit

This block takes the receiver's digital signal strength samples and correlator peak values and produces the two quality figures an IEEE 802.15.4 receiver reports. One figure is an energy-detect value: a measurement started by a pulse averages signal strength over a fixed window of microseconds. The other is a link quality indicator that is frozen a fixed number of microseconds after the preamble is found.

All timing counts a one-cycle microsecond tick from outside. Signal strength samples arrive with a one-cycle strobe, normally one per 16 µs symbol. A control input chooses whether the captured link quality comes from the correlator peak or from the mean of the most recent signal strength samples. A second control input enables a running register that follows that mean on every sample during reception.

Top module: `link_quality_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `ed_value`, `ed_done`, `lqi_value`, `lqi_valid` and `lqi_running` become zero, and all counters and sample history are cleared.
- R2: An `ed_start` pulse clears `ed_done` and begins a measurement. On the clock edge that carries the 128th `us_tick` after the start, `ed_value` is loaded with the sum of all `rssi_data` values strobed from the cycle after the start through that closing cycle, shifted right by 3, and `ed_done` is set. `ed_done` stays high until the next `ed_start`.
- R3: An `ed_start` during a running measurement throws away the partial sum and tick count and restarts the full window. A strobe in the same cycle as `ed_start` is not counted.
- R4: Outside a measurement, strobes and ticks leave `ed_value` and `ed_done` unchanged.
- R5: A `pre_det` pulse clears `lqi_valid` and rearms the delay. On the edge carrying the 64th `us_tick` after it, `lqi_value` is loaded and `lqi_valid` is set. Both hold until the next `pre_det`. A tick in the same cycle as `pre_det` is not counted.
- R6: With `lqi_use_corr` = 1 the captured value is `corr_peak` in the capture cycle. With `lqi_use_corr` = 0 it is the sum of the last eight strobed samples before the capture cycle, shifted right by 3. Samples missing since reset count as zero.
- R7: With `cont_en` = 1, each strobe loads `lqi_running` with the sum of the last eight samples including this one, shifted right by 3. With `cont_en` = 0, `lqi_running` holds its value.
- R8: When the shifted sum of the energy window exceeds 255, `ed_value` is 255 rather than a wrapped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| rssi_stb | input | 1 | Sample strobe for `rssi_data` |
| rssi_data | input | 8 | Digital signal strength sample |
| corr_peak | input | 8 | Correlator peak value |
| pre_det | input | 1 | Preamble-detected pulse |
| ed_start | input | 1 | Starts or restarts an energy measurement |
| lqi_use_corr | input | 1 | 1: link quality from correlator, 0: from signal strength |
| cont_en | input | 1 | Enables running link quality updates |
| ed_value | output | 8 | Energy-detect result |
| ed_done | output | 1 | Energy-detect result valid |
| lqi_value | output | 8 | Captured link quality |
| lqi_valid | output | 1 | Captured link quality valid |
| lqi_running | output | 8 | Running link quality |

## Verification
The bench builds the block with its defaults: a 128-tick energy window, a 64-tick capture delay and an eight-sample mean. It drives the microsecond tick every five clocks, so full windows, mid-window restarts and overlapping capture delays each take a few hundred cycles and many of them fit in one run. Bursts of extra strobes within a window put saturation of the energy result within reach. Aligned symbol strobes with constant data give exact expected averages for the directed cases.

// File: rtl/lqu_pkg.sv
package lqu_pkg;

    localparam int SAMPLE_W = 8;
    localparam logic [31:0] SAMPLE_MAX = (32'd1 << SAMPLE_W) - 32'd1;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic {
        SRC_RSSI = 1'b0,
        SRC_CORR = 1'b1
    } lqi_src_e;

    typedef struct packed {
        logic    flag;
        sample_t value;
    } result_t;

    function automatic sample_t clamp_sample(input logic [31:0] v);
        if (v > SAMPLE_MAX) begin
            return '1;
        end
        return v[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/lqu_ed_avg.sv
module lqu_ed_avg
    import lqu_pkg::*;
#(
    parameter int WINDOW_TICKS = 128,
    parameter int AVG_LOG2     = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    ed_start,
    input  logic    us_tick,
    input  logic    rssi_stb,
    input  sample_t rssi_data,
    output result_t ed_res
);
    localparam int CNT_W = $clog2(WINDOW_TICKS + 1);
    localparam int ACC_W = SAMPLE_W + AVG_LOG2 + 1;
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(WINDOW_TICKS - 1);
    localparam logic [ACC_W-1:0] ACC_MAX   = '1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] ticks;
        logic [ACC_W-1:0] acc;
    } ed_state_t;

    ed_state_t        st_q, st_d;
    result_t          res_q, res_d;
    logic [ACC_W:0]   wide_sum;
    logic [ACC_W-1:0] acc_next;
    logic             closing;

    always_comb begin
        wide_sum = {1'b0, st_q.acc} + (ACC_W + 1)'(rssi_stb ? rssi_data : sample_t'(0));
        acc_next = wide_sum[ACC_W] ? ACC_MAX : wide_sum[ACC_W-1:0];
        closing  = st_q.busy && us_tick && (st_q.ticks == LAST_TICK);
    end

    always_comb begin
        st_d  = st_q;
        res_d = res_q;
        if (ed_start) begin
            st_d       = '0;
            st_d.busy  = 1'b1;
            res_d.flag = 1'b0;
        end else if (st_q.busy) begin
            if (closing) begin
                st_d        = '0;
                res_d.flag  = 1'b1;
                res_d.value = clamp_sample(32'(acc_next >> AVG_LOG2));
            end else begin
                st_d.acc = acc_next;
                if (us_tick) begin
                    st_d.ticks = st_q.ticks + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= '0;
            res_q <= '0;
        end else begin
            st_q  <= st_d;
            res_q <= res_d;
        end
    end

    assign ed_res = res_q;

    // R2: a finished result stays flagged until the next start
    p_done_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (ed_res.flag && !ed_start) |=> ed_res.flag);

    // R2: the tick count never reaches the window length while running
    p_ticks_bound_r2: assert property (@(posedge clk) disable iff (rst)
        st_q.busy |-> (32'(st_q.ticks) < WINDOW_TICKS));

    // R3: a start always withdraws the previous result
    p_start_drops_r3: assert property (@(posedge clk) disable iff (rst)
        ed_start |=> (!ed_res.flag && st_q.busy));

    // R4: idle cycles leave the result untouched
    p_idle_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (!st_q.busy && !ed_start) |=> $stable(ed_res));

    // R8: the partial sum never shrinks inside one window
    p_acc_monotonic_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && !ed_start && !closing) |=> (st_q.acc >= $past(st_q.acc)));

endmodule

// File: rtl/lqu_run_avg.sv
module lqu_run_avg
    import lqu_pkg::*;
#(
    parameter int AVG_LOG2 = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    rssi_stb,
    input  sample_t rssi_data,
    input  logic    cont_en,
    output sample_t avg_now,
    output sample_t running
);
    localparam int DEPTH = 1 << AVG_LOG2;
    localparam int SUM_W = SAMPLE_W + AVG_LOG2;

    logic [DEPTH-1:0][SAMPLE_W-1:0] taps_q;
    logic [SUM_W-1:0]               sum_q, sum_d;
    sample_t                        running_q;

    always_comb begin
        sum_d = sum_q + SUM_W'(rssi_data) - SUM_W'(taps_q[DEPTH-1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            taps_q    <= '0;
            sum_q     <= '0;
            running_q <= '0;
        end else if (rssi_stb) begin
            taps_q <= {taps_q[DEPTH-2:0], rssi_data};
            sum_q  <= sum_d;
            if (cont_en) begin
                running_q <= SAMPLE_W'(sum_d >> AVG_LOG2);
            end
        end
    end

    assign avg_now = SAMPLE_W'(sum_q >> AVG_LOG2);
    assign running = running_q;

    // R7: without an enabled strobe the running value holds
    p_running_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(rssi_stb && cont_en) |=> $stable(running));

    // R6: the mean only moves when a sample arrives
    p_mean_needs_sample_r6: assert property (@(posedge clk) disable iff (rst)
        !rssi_stb |=> $stable(avg_now));

endmodule

// File: rtl/lqu_lqi_snap.sv
module lqu_lqi_snap
    import lqu_pkg::*;
#(
    parameter int DELAY_TICKS = 64
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pre_det,
    input  logic     us_tick,
    input  lqi_src_e src,
    input  sample_t  corr_peak,
    input  sample_t  rssi_avg,
    output result_t  lqi_res
);
    localparam int CNT_W = $clog2(DELAY_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(DELAY_TICKS - 1);

    logic             armed_q, armed_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    result_t          res_q, res_d;

    always_comb begin
        armed_d = armed_q;
        cnt_d   = cnt_q;
        res_d   = res_q;
        if (pre_det) begin
            armed_d    = 1'b1;
            cnt_d      = '0;
            res_d.flag = 1'b0;
        end else if (armed_q && us_tick) begin
            if (cnt_q == LAST_TICK) begin
                armed_d     = 1'b0;
                cnt_d       = '0;
                res_d.flag  = 1'b1;
                res_d.value = (src == SRC_CORR) ? corr_peak : rssi_avg;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            res_q   <= '0;
        end else begin
            armed_q <= armed_d;
            cnt_q   <= cnt_d;
            res_q   <= res_d;
        end
    end

    assign lqi_res = res_q;

    // R5: a preamble pulse withdraws the captured value
    p_pre_clears_r5: assert property (@(posedge clk) disable iff (rst)
        pre_det |=> !lqi_res.flag);

    // R5: a valid capture holds until the next preamble
    p_capture_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (lqi_res.flag && !pre_det) |=> (lqi_res.flag && $stable(lqi_res.value)));

    // R5: a capture only happens on a microsecond tick
    p_capture_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(lqi_res.flag) |-> $past(us_tick));

    // R6: the captured value comes from one of the two sources
    p_capture_source_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(lqi_res.flag) |->
            (lqi_res.value == $past(corr_peak) || lqi_res.value == $past(rssi_avg)));

    // R5: waiting and valid never overlap
    p_armed_excl_r5: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> !lqi_res.flag);

endmodule

// File: rtl/link_quality_unit.sv
module link_quality_unit
    import lqu_pkg::*;
#(
    parameter int ED_WINDOW_US = 128,
    parameter int LQI_DELAY_US = 64,
    parameter int AVG_LOG2     = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                us_tick,
    input  logic                rssi_stb,
    input  logic [SAMPLE_W-1:0] rssi_data,
    input  logic [SAMPLE_W-1:0] corr_peak,
    input  logic                pre_det,
    input  logic                ed_start,
    input  logic                lqi_use_corr,
    input  logic                cont_en,
    output logic [SAMPLE_W-1:0] ed_value,
    output logic                ed_done,
    output logic [SAMPLE_W-1:0] lqi_value,
    output logic                lqi_valid,
    output logic [SAMPLE_W-1:0] lqi_running
);
    result_t  ed_res;
    result_t  lqi_res;
    sample_t  mean_now;
    sample_t  mean_run;
    lqi_src_e src_sel;

    assign src_sel = lqi_use_corr ? SRC_CORR : SRC_RSSI;

    lqu_ed_avg #(
        .WINDOW_TICKS(ED_WINDOW_US),
        .AVG_LOG2    (AVG_LOG2)
    ) u_ed (
        .clk      (clk),
        .rst      (rst),
        .ed_start (ed_start),
        .us_tick  (us_tick),
        .rssi_stb (rssi_stb),
        .rssi_data(rssi_data),
        .ed_res   (ed_res)
    );

    lqu_run_avg #(
        .AVG_LOG2(AVG_LOG2)
    ) u_run (
        .clk      (clk),
        .rst      (rst),
        .rssi_stb (rssi_stb),
        .rssi_data(rssi_data),
        .cont_en  (cont_en),
        .avg_now  (mean_now),
        .running  (mean_run)
    );

    lqu_lqi_snap #(
        .DELAY_TICKS(LQI_DELAY_US)
    ) u_snap (
        .clk      (clk),
        .rst      (rst),
        .pre_det  (pre_det),
        .us_tick  (us_tick),
        .src      (src_sel),
        .corr_peak(corr_peak),
        .rssi_avg (mean_now),
        .lqi_res  (lqi_res)
    );

    assign ed_value    = ed_res.value;
    assign ed_done     = ed_res.flag;
    assign lqi_value   = lqi_res.value;
    assign lqi_valid   = lqi_res.flag;
    assign lqi_running = mean_run;

    // R1: every output is cleared one edge after reset
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!ed_done && !lqi_valid && ed_value == '0 &&
                 lqi_value == '0 && lqi_running == '0));

endmodule

// File: tb/test_link_quality_unit.sv
module test_link_quality_unit;

    localparam int WIN = 128;
    localparam int DLY = 64;
    localparam int NAV = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       us_tick = 1'b0;
    logic       rssi_stb = 1'b0;
    logic [7:0] rssi_data = 8'd0;
    logic [7:0] corr_peak = 8'd0;
    logic       pre_det = 1'b0;
    logic       ed_start = 1'b0;
    logic       lqi_use_corr = 1'b0;
    logic       cont_en = 1'b0;
    logic [7:0] ed_value;
    logic       ed_done;
    logic [7:0] lqi_value;
    logic       lqi_valid;
    logic [7:0] lqi_running;

    always #10 clk = ~clk;

    link_quality_unit i_link_quality_unit (
        .clk(clk), .rst(rst), .us_tick(us_tick), .rssi_stb(rssi_stb),
        .rssi_data(rssi_data), .corr_peak(corr_peak), .pre_det(pre_det),
        .ed_start(ed_start), .lqi_use_corr(lqi_use_corr), .cont_en(cont_en),
        .ed_value(ed_value), .ed_done(ed_done), .lqi_value(lqi_value),
        .lqi_valid(lqi_valid), .lqi_running(lqi_running)
    );

    int vectors = 0;
    int errors  = 0;
    bit cmp_on  = 1'b0;

    // reference state, derived from the requirements
    int m_busy, m_ecnt, m_acc, m_edv, m_edd;
    int m_win [NAV];
    int m_sum, m_run;
    int m_arm, m_lcnt, m_lqv, m_lqd;

    function automatic int clamp8(input int v);
        return (v > 255) ? 255 : v;
    endfunction

    always @(posedge clk) begin
        int old_mean;
        int nacc;
        if (rst) begin
            m_busy = 0; m_ecnt = 0; m_acc = 0; m_edv = 0; m_edd = 0;
            for (int i = 0; i < NAV; i++) m_win[i] = 0;
            m_sum = 0; m_run = 0;
            m_arm = 0; m_lcnt = 0; m_lqv = 0; m_lqd = 0;
        end else begin
            old_mean = m_sum / NAV;
            if (pre_det) begin
                m_arm = 1; m_lcnt = 0; m_lqd = 0;
            end else if (m_arm != 0 && us_tick) begin
                if (m_lcnt == DLY - 1) begin
                    m_lqv = lqi_use_corr ? int'(corr_peak) : old_mean;
                    m_lqd = 1; m_arm = 0; m_lcnt = 0;
                end else m_lcnt++;
            end
            if (ed_start) begin
                m_busy = 1; m_acc = 0; m_ecnt = 0; m_edd = 0;
            end else if (m_busy != 0) begin
                nacc = m_acc + (rssi_stb ? int'(rssi_data) : 0);
                if (us_tick && m_ecnt == WIN - 1) begin
                    m_edv = clamp8(nacc / NAV); m_edd = 1; m_busy = 0;
                    m_acc = 0; m_ecnt = 0;
                end else begin
                    m_acc = nacc;
                    if (us_tick) m_ecnt++;
                end
            end
            if (rssi_stb) begin
                m_sum = m_sum + int'(rssi_data) - m_win[NAV-1];
                for (int i = NAV - 1; i > 0; i--) m_win[i] = m_win[i-1];
                m_win[0] = int'(rssi_data);
                if (cont_en) m_run = m_sum / NAV;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R2", "ed_value", int'(ed_value), m_edv);
        check("R2", "ed_done", int'(ed_done), m_edd);
        check("R6", "lqi_value", int'(lqi_value), m_lqv);
        check("R5", "lqi_valid", int'(lqi_valid), m_lqd);
        check("R7", "lqi_running", int'(lqi_running), m_run);
    endtask

    // stimulus state
    int tick_div = 0;
    int sym_cnt  = 0;
    bit burst_en = 1'b0;
    bit data_fix = 1'b1;
    int data_val = 0;
    bit corr_fix = 1'b0;
    int corr_val = 0;
    bit pend_start = 1'b0;
    bit pend_pre   = 1'b0;

    task automatic step();
        @(negedge clk);
        if (cmp_on) compare_all();
        tick_div = (tick_div == 4) ? 0 : tick_div + 1;
        us_tick  = (tick_div == 4);
        if (us_tick) sym_cnt = (sym_cnt + 1) % 16;
        rssi_stb  = (us_tick && sym_cnt == 15) || (burst_en && ($urandom % 4 == 0));
        rssi_data = data_fix ? 8'(data_val) : 8'($urandom);
        corr_peak = corr_fix ? 8'(corr_val) : 8'($urandom);
        ed_start  = pend_start; pend_start = 1'b0;
        pre_det   = pend_pre;   pend_pre   = 1'b0;
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wait_ed();
        steps(2);
        for (int i = 0; i < 2000 && !ed_done; i++) step();
    endtask

    task automatic wait_lqi();
        steps(2);
        for (int i = 0; i < 1000 && !lqi_valid; i++) step();
    endtask

    initial begin
        int held;
        void'($urandom(32'd1234));
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cmp_on = 1'b1;
        // R1: reset state at the ports
        check("R1", "ed_value after reset", int'(ed_value), 0);
        check("R1", "ed_done after reset", int'(ed_done), 0);
        check("R1", "lqi_valid after reset", int'(lqi_valid), 0);
        check("R1", "lqi_running after reset", int'(lqi_running), 0);
        rst = 1'b0;

        // R2: constant aligned samples give that constant
        data_val = 40; pend_start = 1'b1;
        wait_ed();
        check("R2", "window mean of 40", int'(ed_value), 40);
        check("R2", "done after window", int'(ed_done), 1);

        // R4: idle strobes leave the result alone
        data_fix = 1'b0;
        steps(300);
        check("R4", "idle ed_value", int'(ed_value), 40);
        check("R4", "idle ed_done", int'(ed_done), 1);

        // R3: restart mid-window discards earlier samples
        data_fix = 1'b1; data_val = 250; pend_start = 1'b1;
        steps(300);
        data_val = 16; pend_start = 1'b1;
        wait_ed();
        check("R3", "restarted window mean", int'(ed_value), 16);

        // R8: dense full-scale samples saturate
        burst_en = 1'b1; data_val = 255; pend_start = 1'b1;
        wait_ed();
        check("R8", "saturated ed_value", int'(ed_value), 255);
        burst_en = 1'b0;

        // R5, R6: correlator-sourced capture
        lqi_use_corr = 1'b1; corr_fix = 1'b1; corr_val = 165; pend_pre = 1'b1;
        steps(2);
        check("R5", "valid cleared by preamble", int'(lqi_valid), 0);
        wait_lqi();
        check("R5", "valid after delay", int'(lqi_valid), 1);
        check("R6", "correlator capture", int'(lqi_value), 165);

        // R7, R6: running mean and signal-strength capture
        cont_en = 1'b1; data_val = 100; lqi_use_corr = 1'b0;
        steps(800);
        check("R7", "running mean of 100", int'(lqi_running), 100);
        pend_pre = 1'b1;
        wait_lqi();
        check("R6", "signal strength capture", int'(lqi_value), 100);
        cont_en = 1'b0; data_val = 7;
        steps(400);
        check("R7", "running held while disabled", int'(lqi_running), 100);
        check("R5", "capture held", int'(lqi_value), 100);
        corr_fix = 1'b0;

        // random episodes, checked every cycle against the reference
        for (int ep = 0; ep < 40; ep++) begin
            burst_en     = ($urandom % 3 == 0);
            data_fix     = ($urandom % 4 == 0);
            data_val     = int'($urandom % 256);
            cont_en      = ($urandom % 2 == 1);
            lqi_use_corr = ($urandom % 2 == 1);
            pend_start   = ($urandom % 2 == 1);
            pend_pre     = ($urandom % 2 == 1);
            held = 50 + int'($urandom % 850);
            steps(held);
        end
        steps(1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual still running, expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule